// File: doc/BRIEF.md
# I2C Slave Front End for a Byte-Addressed Memory

This block connects a 256-location byte memory core to a two-wire I2C bus as a slave. It watches the bus for start, repeated start and stop conditions and compares the 7-bit device address against its own. On a write it takes one memory address byte and then any number of data bytes. A single address counter serves both directions: reads always begin where the counter currently points, so a master that wants a chosen location first sends the address in a write transfer with no data, then issues a repeated start and reads.

The block only ever pulls SDA low, and it has no SCL output, so it cannot stretch the clock. A busy input from the memory core makes the slave refuse its own address. A master can therefore poll with address bytes until the core is free. Writes step through the current 8-byte page and wrap inside it. Reads step linearly across the whole space and wrap from FFh to 00h. Locations in a reserved window read back as a fixed fill value, and the counter still steps through that window.

Top module: `i2c_mem_slave`

## Requirements
- R1: Out of reset, sda_oe and mem_we are low and the address counter, visible on mem_addr, is 00h.
- R2: The slave ACKs (pulls SDA low in the ninth clock) only an address byte whose upper seven bits equal DEV_ADDR. After any other address it ACKs nothing and writes nothing until the next start.
- R3: In a write transfer (bit 0 of the address byte = 0), the byte after the address byte loads the counter. Each following byte is ACKed and written through a single-cycle mem_we pulse to the counter location, while SCL is low.
- R4: After each written data byte the counter advances within its 8-byte page: the low three bits count up and wrap, and the upper five bits stay as they are.
- R5: A read transfer (bit 0 of the address byte = 1) returns data starting at the current counter value, for example the location after the last byte written.
- R6: An address byte with no data, followed by a repeated start and a read, makes the read begin at that address.
- R7: During a read the counter advances after every byte across page boundaries and rolls from FFh to 00h.
- R8: After the master NACKs a read byte, the slave leaves SDA released until the next start or stop.
- R9: While mem_busy is high when the device address byte completes, the slave does not ACK it. Once mem_busy is low it ACKs normally.
- R10: Reads of locations RSV_LO..RSV_HI (default 40h..EFh) return FFh, and the counter passes through them.
- R11: sda_oe changes only while SCL is low, so the slave never creates a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_addr | output | 8 | Memory location for read data and for writes |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Read data for mem_addr, combinational from the core |
| mem_busy | input | 1 | Core is busy; the device address is refused |

## Verification
The bench builds the block with its default parameters: device address 50h, an 8-byte page, a reserved window 40h..EFh and a two-stage synchronizer. With these values a short transfer can reach a page wrap at 07h→00h, a read crossing from 07h into 08h, the FFh→00h rollover, and both edges of the reserved window (3Fh/40h and EFh/F0h). The bench models the memory core with a known pattern, and it raises mem_busy in one scenario so that acknowledge polling is exercised.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADEV,
        ST_WADR,
        ST_AWADR,
        ST_WDAT,
        ST_AWDAT,
        ST_RDAT,
        ST_RACK
    } st_e;

    typedef struct packed {
        st_e        st;
        logic [3:0] bits;
        logic [7:0] sh;
        logic       rw;
        logic       oe;
        logic [7:0] ctr;
        logic       we;
        logic [7:0] wadr;
        logic [7:0] wdat;
        logic       mack;
    } regs_t;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_o    = scl_pipe[STAGES-1];
    assign sda_o    = sda_pipe[STAGES-1];
    assign scl_rise = scl_o & ~scl_prev;
    assign scl_fall = ~scl_o & scl_prev;
    // SDA edges while SCL stays high mark start (falling) and stop (rising)
    assign start_o  = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_o   = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_addr_step.sv
module i2c_addr_step #(
    parameter int AW   = 8,
    parameter int PAGE = 8
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] lin_nxt,
    output logic [AW-1:0] page_nxt
);
    localparam int PW = $clog2(PAGE);

    assign lin_nxt = cur + 1'b1;

    generate
        if (PW == 0) begin : g_nopage
            assign page_nxt = cur;
        end else if (PW >= AW) begin : g_fullpage
            assign page_nxt = cur + 1'b1;
        end else begin : g_page
            logic [PW-1:0] low_inc;
            assign low_inc  = cur[PW-1:0] + 1'b1;
            assign page_nxt = {cur[AW-1:PW], low_inc};
        end
    endgenerate
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         PAGE     = 8,
    parameter int         STAGES   = 2,
    parameter logic [7:0] RSV_LO   = 8'h40,
    parameter logic [7:0] RSV_HI   = 8'hEF,
    parameter logic [7:0] FILL     = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    output logic       mem_we,
    input  logic [7:0] mem_rdata,
    input  logic       mem_busy
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic [7:0] lin_nxt, page_nxt, rd_byte;
    logic dev_ack_w;
    regs_t q, d;

    i2c_bus_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_o(start_c), .stop_o(stop_c)
    );

    i2c_addr_step #(.AW(8), .PAGE(PAGE)) u_step (
        .cur(q.ctr), .lin_nxt(lin_nxt), .page_nxt(page_nxt)
    );

    // Reserved window reads back a fixed fill value
    assign rd_byte = (q.ctr >= RSV_LO && q.ctr <= RSV_HI) ? FILL : mem_rdata;

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_c) begin
            d.st   = ST_DEV;
            d.bits = '0;
            d.oe   = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_DEV, ST_WADR, ST_WDAT: begin
                    if (scl_rise && q.bits != BYTE_BITS) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall && q.bits == BYTE_BITS) begin
                        d.bits = '0;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:1] == DEV_ADDR && !mem_busy) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = ST_ADEV;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_WADR) begin
                            d.ctr = q.sh;
                            d.oe  = 1'b1;
                            d.st  = ST_AWADR;
                        end else begin
                            d.we   = 1'b1;
                            d.wadr = q.ctr;
                            d.wdat = q.sh;
                            d.ctr  = page_nxt;
                            d.oe   = 1'b1;
                            d.st   = ST_AWDAT;
                        end
                    end
                end
                ST_ADEV: begin
                    if (scl_fall) begin
                        d.bits = '0;
                        if (q.rw) begin
                            d.sh = rd_byte;
                            d.oe = ~rd_byte[7];
                            d.st = ST_RDAT;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_WADR;
                        end
                    end
                end
                ST_AWADR, ST_AWDAT: begin
                    if (scl_fall) begin
                        d.oe   = 1'b0;
                        d.bits = '0;
                        d.st   = ST_WDAT;
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        d.bits = q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (q.bits == BYTE_BITS) begin
                            d.oe  = 1'b0;
                            d.ctr = lin_nxt;
                            d.st  = ST_RACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh   = rd_byte;
                            d.oe   = ~rd_byte[7];
                            d.bits = '0;
                            d.st   = ST_RDAT;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bits: '0, sh: '0, rw: 1'b0, oe: 1'b0,
                   ctr: '0, we: 1'b0, wadr: '0, wdat: '0, mack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dev_ack_w = (q.st == ST_ADEV);
    assign sda_oe    = q.oe;
    assign mem_we    = q.we;
    assign mem_wdata = q.wdat;
    assign mem_addr  = q.we ? q.wadr : q.ctr;
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic mem_we,
    input logic mem_busy,
    input logic dev_ack
);
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    a_r3_we_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    a_r3_we_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !scl_i);

    a_r9_no_ack_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> !$past(mem_busy));

    a_r3_we_no_dev_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !dev_ack);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .mem_we(mem_we), .mem_busy(mem_busy), .dev_ack(dev_ack_w)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb;
    localparam int HALF = 8;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, mem_we, mem_busy = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic sda_line;
    logic [7:0] mem [256];
    int n_chk = 0, n_bad = 0, r11_viol = 0;
    logic sda_oe_prev = 1'b0;
    bit done = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    i2c_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .mem_busy(mem_busy)
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    initial for (int i = 0; i < 256; i++) mem[i] = pat(i[7:0]);

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (rst_n && sda_oe != sda_oe_prev && scl_m) r11_viol++;
        sda_oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b0; wt(HALF);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        sda_m = 1'b1; wt(HALF);
    endtask

    task automatic m_write(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(HALF);
            scl_m = 1'b1; wt(HALF);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wt(HALF);
        scl_m = 1'b1; wt(HALF / 2);
        ack = ~sda_line; wt(HALF / 2);
        scl_m = 1'b0;
    endtask

    task automatic m_read(input logic ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(HALF);
            scl_m = 1'b1; wt(HALF / 2);
            b[i] = sda_line; wt(HALF / 2);
            scl_m = 1'b0;
        end
        sda_m = ~ack; wt(HALF);
        scl_m = 1'b1; wt(HALF);
        scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a);
        logic ak;
        m_start;
        m_write({DEV, 1'b0}, ak); chk("R6 dev ack", {7'd0, ak}, 8'd1);
        m_write(a, ak);           chk("R6 addr ack", {7'd0, ak}, 8'd1);
    endtask

    task automatic t_reset;
        chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
        chk("R1 mem_we", {7'd0, mem_we}, 8'd0);
        chk("R1 counter", mem_addr, 8'h00);
    endtask

    task automatic t_write_basic;
        logic ak;
        m_start;
        m_write({DEV, 1'b0}, ak); chk("R2 match ack", {7'd0, ak}, 8'd1);
        m_write(8'h10, ak);       chk("R3 addr ack", {7'd0, ak}, 8'd1);
        m_write(8'h11, ak);       chk("R3 data ack", {7'd0, ak}, 8'd1);
        m_write(8'h22, ak);
        m_write(8'h33, ak);
        m_stop; wt(4);
        chk("R3 mem10", mem[8'h10], 8'h11);
        chk("R3 mem11", mem[8'h11], 8'h22);
        chk("R3 mem12", mem[8'h12], 8'h33);
    endtask

    task automatic t_read_current;
        logic ak; logic [7:0] b;
        m_start;
        m_write({DEV, 1'b1}, ak); chk("R5 dev ack", {7'd0, ak}, 8'd1);
        m_read(1'b0, b);          chk("R5 read at counter", b, pat(8'h13));
        m_stop;
    endtask

    task automatic t_dummy;
        logic ak; logic [7:0] b;
        set_ptr(8'h11);
        m_start;
        m_write({DEV, 1'b1}, ak);
        m_read(1'b1, b); chk("R6 first", b, 8'h22);
        m_read(1'b0, b); chk("R6 second", b, 8'h33);
        m_stop;
    endtask

    task automatic t_roll;
        logic ak; logic [7:0] b;
        set_ptr(8'hFE);
        m_start; m_write({DEV, 1'b1}, ak);
        m_read(1'b1, b); chk("R7 FE", b, pat(8'hFE));
        m_read(1'b1, b); chk("R7 FF", b, pat(8'hFF));
        m_read(1'b0, b); chk("R7 rolled 00", b, pat(8'h00));
        m_stop;
        set_ptr(8'h06);
        m_start; m_write({DEV, 1'b1}, ak);
        m_read(1'b1, b); chk("R7 06", b, pat(8'h06));
        m_read(1'b1, b); chk("R7 07", b, pat(8'h07));
        m_read(1'b0, b); chk("R7 no page wrap 08", b, pat(8'h08));
        // R8: after NACK the slave keeps SDA released through an extra clock
        wt(HALF);
        chk("R8 oe after nack", {7'd0, sda_oe}, 8'd0);
        scl_m = 1'b1; wt(HALF / 2);
        chk("R8 line high", {7'd0, sda_line}, 8'd1);
        wt(HALF / 2); scl_m = 1'b0; wt(HALF);
        chk("R8 oe still low", {7'd0, sda_oe}, 8'd0);
        m_stop;
    endtask

    task automatic t_page_wrap;
        logic ak;
        set_ptr(8'h06);
        m_write(8'hC1, ak);
        m_write(8'hC2, ak);
        m_write(8'hC3, ak); chk("R4 third ack", {7'd0, ak}, 8'd1);
        m_stop; wt(4);
        chk("R4 mem06", mem[8'h06], 8'hC1);
        chk("R4 mem07", mem[8'h07], 8'hC2);
        chk("R4 wrapped to 00", mem[8'h00], 8'hC3);
        chk("R4 mem08 untouched", mem[8'h08], pat(8'h08));
    endtask

    task automatic t_mismatch;
        logic ak;
        m_start;
        m_write({7'h23, 1'b0}, ak); chk("R2 other addr nack", {7'd0, ak}, 8'd0);
        m_write(8'h30, ak);         chk("R2 no ack after", {7'd0, ak}, 8'd0);
        m_write(8'h99, ak);
        m_stop; wt(4);
        chk("R2 no write", mem[8'h30], pat(8'h30));
    endtask

    task automatic t_busy;
        logic ak;
        mem_busy = 1'b1;
        m_start;
        m_write({DEV, 1'b0}, ak); chk("R9 busy nack", {7'd0, ak}, 8'd0);
        m_stop;
        mem_busy = 1'b0;
        m_start;
        m_write({DEV, 1'b0}, ak); chk("R9 ack after busy", {7'd0, ak}, 8'd1);
        m_write(8'h31, ak);
        m_write(8'h77, ak);
        m_stop; wt(4);
        chk("R9 write after poll", mem[8'h31], 8'h77);
    endtask

    task automatic t_reserved;
        logic ak; logic [7:0] b;
        set_ptr(8'h3F);
        m_start; m_write({DEV, 1'b1}, ak);
        m_read(1'b1, b); chk("R10 3F real", b, pat(8'h3F));
        m_read(1'b1, b); chk("R10 40 fill", b, 8'hFF);
        m_read(1'b0, b); chk("R10 41 fill", b, 8'hFF);
        m_stop;
        set_ptr(8'hEF);
        m_start; m_write({DEV, 1'b1}, ak);
        m_read(1'b1, b); chk("R10 EF fill", b, 8'hFF);
        m_read(1'b0, b); chk("R10 F0 real", b, pat(8'hF0));
        m_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wt(5);
        t_reset;
        rst_n = 1'b1;
        wt(5);
        t_write_basic;
        t_read_current;
        t_dummy;
        t_roll;
        t_page_wrap;
        t_mismatch;
        t_busy;
        t_reserved;
        chk("R11 sda_oe moves only with SCL low", r11_viol[7:0], 8'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule